// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block turns a short packet into the line signals of a low-speed USB pair, at eight clocks per bit from a 12 MHz clock. A single start pulse launches a send. The block first puts idle J on the pair and then takes the bus. It sends the sync byte, which it makes itself, and the following bytes least significant bit first in NRZI form, with a stuffed toggle after every run of six ones. It closes with two bit times of SE0 and one of J, then lets go of the bus.

Payload bytes come in over a valid/ready stream. The block raises `in_ready_o` while its one-byte staging register is empty and payload bytes remain. A byte moves when `in_valid_i` and `in_ready_o` are both high at a clock edge. The source may hold back for as long as it likes while `in_ready_o` is high, but each byte must have moved before the byte ahead of it has been fully shifted out. That gives at least eight bit times from the rise of `in_ready_o`. The source must keep `in_valid_i` and `in_data_i` stable until the byte moves.

In handshake mode the block sends sync plus one fixed PID byte and fetches nothing. The block holds the active device address. A pending address is taken into it when a data packet ends, never when a handshake ends.

Top module: `usbtx_top`

## Requirements
- R1: Line states are driven as K = (`dp_o`=1, `dm_o`=0), J = (`dp_o`=0, `dm_o`=1) and SE0 = (0, 0). Every bit, stuffed or not, lasts exactly `BIT_CLKS` (8) clock cycles.
- R2: A start pulse seen while idle gives one cycle with `oe_o` low, J on the pair and `busy_o` high. In the next cycle `oe_o` rises and the first sync bit begins.
- R3: The first byte sent is the sync byte 0x80, sent least significant bit first (K J K J K J K K). `byte_cnt_i` counts it. A count of 1 (or 0) sends only the sync byte.
- R4: NRZI coding: a 0 bit toggles the line and a 1 bit holds it. Each byte is sent least significant bit first, starting from idle J.
- R5: After six consecutive 1 bits, one extra toggle bit is inserted. The run counter clears on every toggle, data or stuffed. Runs carry across byte boundaries, and a stuffed bit after the last data bit is still sent before SE0.
- R6: After the last bit the pair shows SE0 for two bit times and then J for one bit time. In the following cycle `oe_o` and `busy_o` are low together.
- R7: In data mode exactly `byte_cnt_i`-1 payload bytes are taken over the valid/ready stream, in order. `in_ready_o` is high only while busy, with the staging register empty and bytes still owed.
- R8: In handshake mode (`hs_i`=1) the PID byte is 0xD2 (ACK) when `hs_nak_i`=0, or 0x5A (NAK) when `hs_nak_i`=1. `in_ready_o` stays low throughout.
- R9: `addr_o` resets to 0. It loads `pend_addr_i` in the same cycle that `busy_o` falls after a data packet, and it does not change after a handshake packet.
- R10: A start pulse while `busy_o` is high is ignored. The packet in flight keeps its exact waveform and length, and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock (eight per bit) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a packet |
| hs_i | input | 1 | 1 = handshake packet, 0 = data packet |
| hs_nak_i | input | 1 | Handshake kind: 0 = ACK, 1 = NAK |
| byte_cnt_i | input | CNT_W | Bytes in the packet, sync included |
| in_valid_i | input | 1 | Payload byte present |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Staging register wants a byte |
| pend_addr_i | input | ADDR_W | Device address waiting to take effect |
| addr_o | output | ADDR_W | Active device address |
| dp_o | output | 1 | D+ line value |
| dm_o | output | 1 | D- line value |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |

## Verification
The bench builds the block with its defaults: eight clocks per bit, a stuffing run of six, a 4-bit byte count and a 7-bit address. With these values every one-byte payload from 0x00 to 0xFF can be sent in turn, each compared cycle by cycle with an encoder model worked out in the bench. That sweep covers every stuffing position inside a byte and every carry from the sync byte. Multi-byte runs of ones, a sync-only packet, both handshakes, late sources and a start pulse injected mid-packet reach the cross-byte stuffing, fetch and address-commit corners.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_PREP,
    TX_DATA,
    TX_SE0,
    TX_JEND
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
endpackage

// File: rtl/usbtx_bitclk.sv
module usbtx_bitclk #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(BIT_CLKS - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run_i || phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick_o = run_i && (phase == LAST);

  // R1: phase never leaves one bit period
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
  // R1: a stopped timer restarts from phase zero
  a_r1_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> phase == '0);
endmodule

// File: rtl/usbtx_nrzi.sv
module usbtx_nrzi #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic slot_i,
  input  logic bit_i,
  output logic line_k_o,
  output logic run_full_o
);
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

  logic [RW-1:0] ones;

  assign run_full_o = (ones == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_k_o <= 1'b0;
      ones     <= '0;
    end else if (clear_i) begin
      line_k_o <= 1'b0;
      ones     <= '0;
    end else if (slot_i) begin
      if (run_full_o || !bit_i) begin
        line_k_o <= ~line_k_o;
        ones     <= '0;
      end else begin
        ones <= ones + 1'b1;
      end
    end
  end

  // R5: the run of ones never exceeds the stuffing limit
  a_r5_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX);
  // R5: a slot taken at a full run always toggles the line
  a_r5_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && run_full_o && !clear_i |=> line_k_o != $past(line_k_o));
  // R4: a 1 bit outside stuffing holds the line
  a_r4_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && bit_i && !run_full_o && !clear_i |=> $stable(line_k_o));
endmodule

// File: rtl/usbtx_ctrl.sv
module usbtx_ctrl
  import usbtx_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hs_i,
  input  logic              hs_nak_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] pend_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              tick_i,
  input  logic              run_full_i,
  output tx_state_e         state_o,
  output logic              run_o,
  output logic              clear_o,
  output logic              slot_o,
  output logic              bit_o
);
  tx_state_e        st;
  logic [7:0]       sh;
  logic [7:0]       stage;
  logic [3:0]       nb;
  logic [CNT_W-1:0] left;
  logic             stage_full;
  logic             hs_q;
  logic             eop_second;
  logic             ending;
  logic             data_slot;
  logic             stuff_slot;
  logic             take_stage;
  logic             accept;

  always_comb begin
    ending     = (st == TX_DATA) && tick_i && !run_full_i && (nb == 4'd0) && (left == '0);
    stuff_slot = (st == TX_DATA) && tick_i && run_full_i;
    data_slot  = (st == TX_PREP) || ((st == TX_DATA) && tick_i && !run_full_i && !ending);
    take_stage = data_slot && (nb == 4'd0);
    slot_o     = stuff_slot || data_slot;
    bit_o      = take_stage ? stage[0] : sh[0];
    in_ready_o = ((st == TX_PREP) || (st == TX_DATA)) && !hs_q && !stage_full && (left != '0);
    accept     = in_ready_o && in_valid_i;
    clear_o    = (st == TX_IDLE);
    run_o      = (st == TX_DATA) || (st == TX_SE0) || (st == TX_JEND);
  end

  assign state_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= TX_IDLE;
      sh         <= '0;
      stage      <= '0;
      nb         <= '0;
      left       <= '0;
      stage_full <= 1'b0;
      hs_q       <= 1'b0;
      eop_second <= 1'b0;
      addr_o     <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (start_i) begin
            st   <= TX_PREP;
            hs_q <= hs_i;
            sh   <= SYNC_BYTE;
            nb   <= 4'd8;
            if (hs_i) begin
              stage      <= hs_nak_i ? PID_NAK : PID_ACK;
              stage_full <= 1'b1;
              left       <= CNT_W'(1);
            end else begin
              stage_full <= 1'b0;
              left       <= (byte_cnt_i > CNT_W'(1)) ? byte_cnt_i - CNT_W'(1) : '0;
            end
          end
        end
        TX_PREP: st <= TX_DATA;
        TX_DATA: begin
          if (ending) begin
            st         <= TX_SE0;
            eop_second <= 1'b0;
          end
        end
        TX_SE0: begin
          if (tick_i) begin
            if (eop_second) st <= TX_JEND;
            eop_second <= 1'b1;
          end
        end
        TX_JEND: begin
          if (tick_i) begin
            st <= TX_IDLE;
            if (!hs_q) addr_o <= pend_addr_i;
          end
        end
        default: st <= TX_IDLE;
      endcase

      if (data_slot) begin
        if (take_stage) begin
          sh         <= {1'b0, stage[7:1]};
          nb         <= 4'd7;
          left       <= left - 1'b1;
          stage_full <= 1'b0;
        end else begin
          sh <= {1'b0, sh[7:1]};
          nb <= nb - 1'b1;
        end
      end

      if (accept) begin
        stage      <= in_data_i;
        stage_full <= 1'b1;
      end
    end
  end

  // R9: the active address moves only at the end of a data packet
  a_r9_addr_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !((st == TX_JEND) && tick_i && !hs_q) |=> $stable(addr_o));
  // R10: a start pulse during a packet never restarts the sequence
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != TX_IDLE) && start_i |=> st != TX_PREP);
  // R8: no byte is fetched in handshake mode
  a_r8_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_DATA) && hs_q |-> !in_ready_o);
endmodule

// File: rtl/usbtx_top.sv
module usbtx_top
  import usbtx_pkg::*;
#(
  parameter int BIT_CLKS  = 8,
  parameter int STUFF_RUN = 6,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hs_i,
  input  logic              hs_nak_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] pend_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o
);
  tx_state_e st;
  logic      run;
  logic      tick;
  logic      clear;
  logic      slot;
  logic      slot_bit;
  logic      line_k;
  logic      run_full;

  usbtx_bitclk #(.BIT_CLKS(BIT_CLKS)) u_bitclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  usbtx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .slot_i     (slot),
    .bit_i      (slot_bit),
    .line_k_o   (line_k),
    .run_full_o (run_full)
  );

  usbtx_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .hs_i        (hs_i),
    .hs_nak_i    (hs_nak_i),
    .byte_cnt_i  (byte_cnt_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .pend_addr_i (pend_addr_i),
    .addr_o      (addr_o),
    .tick_i      (tick),
    .run_full_i  (run_full),
    .state_o     (st),
    .run_o       (run),
    .clear_o     (clear),
    .slot_o      (slot),
    .bit_o       (slot_bit)
  );

  always_comb begin
    oe_o   = run;
    busy_o = (st != TX_IDLE);
    case (st)
      TX_DATA: begin dp_o = line_k;  dm_o = ~line_k; end
      TX_SE0:  begin dp_o = 1'b0;    dm_o = 1'b0;    end
      default: begin dp_o = 1'b0;    dm_o = 1'b1;    end
    endcase
  end

  // R2: the bus is taken only while J is already on the pair
  a_r2_j_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(!dp_o && dm_o && busy_o));
  // R6: the bus is released only after the closing J
  a_r6_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> $past(!dp_o && dm_o) && !busy_o);
  // R1: the pair never shows both lines high
  a_r1_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_o && dm_o));
endmodule

// File: tb/usbtx_top_tb.sv
`timescale 1ns/1ps
module usbtx_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       hs_i = 1'b0;
  logic       hs_nak_i = 1'b0;
  logic [3:0] byte_cnt_i = '0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o;
  logic [6:0] pend_addr_i = '0;
  logic [6:0] addr_o;
  logic       dp_o, dm_o, oe_o, busy_o;

  int total = 0;
  int bad = 0;

  logic [7:0] src_q [0:15];
  int src_i = 0, src_n = 0, src_dly = 0, src_wait = 0;
  logic xfer = 1'b0;

  logic [1:0] exp_tr [0:1023];
  logic [1:0] got_tr [0:1023];
  int exp_len;

  always #5 clk = ~clk;

  usbtx_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hs_i(hs_i), .hs_nak_i(hs_nak_i),
    .byte_cnt_i(byte_cnt_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .pend_addr_i(pend_addr_i), .addr_o(addr_o),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // byte source: valid/ready with a programmable pause before each byte
  initial begin
    forever begin
      @(negedge clk);
      if (xfer) begin
        src_i++;
        in_valid_i = 1'b0;
        src_wait = src_dly;
        xfer = 1'b0;
      end
      if (!in_valid_i && src_i < src_n) begin
        if (src_wait == 0) begin
          in_valid_i = 1'b1;
          in_data_i = src_q[src_i];
        end else begin
          src_wait--;
        end
      end
      if (in_valid_i && in_ready_o) xfer = 1'b1;
    end
  end

  task automatic push_sym(input logic [1:0] s, input int reps);
    for (int k = 0; k < reps; k++) begin
      exp_tr[exp_len] = s;
      exp_len++;
    end
  endtask

  // expected waveform: K=2'b10, J=2'b01, SE0=2'b00 as {dp,dm}
  task automatic build_exp(input logic hs, input logic nak, input int cnt);
    logic line_k;
    int ones;
    int nbytes;
    logic [7:0] b;
    line_k = 1'b0;
    ones = 0;
    exp_len = 0;
    nbytes = hs ? 2 : ((cnt < 1) ? 1 : cnt);
    for (int i = 0; i < nbytes; i++) begin
      if (i == 0) b = 8'h80;
      else if (hs) b = nak ? 8'h5A : 8'hD2;
      else b = src_q[i-1];
      for (int k = 0; k < 8; k++) begin
        if (!b[k]) begin
          line_k = ~line_k;
          ones = 0;
        end else begin
          ones++;
        end
        push_sym(line_k ? 2'b10 : 2'b01, 8);
        if (ones == 6) begin
          line_k = ~line_k;
          ones = 0;
          push_sym(line_k ? 2'b10 : 2'b01, 8);
        end
      end
    end
    push_sym(2'b00, 16);
    push_sym(2'b01, 8);
  endtask

  task automatic run_pkt(input logic hs, input logic nak, input int cnt,
                         input int dly, input int inject_at, input string tag);
    int n;
    int first_bad;
    logic saw_rdy;
    build_exp(hs, nak, cnt);
    src_i = 0;
    src_n = hs ? 0 : ((cnt > 1) ? cnt - 1 : 0);
    src_dly = dly;
    src_wait = dly;
    @(negedge clk);
    start_i = 1'b1;
    hs_i = hs;
    hs_nak_i = nak;
    byte_cnt_i = 4'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    chk(!oe_o && busy_o && !dp_o && dm_o, "R2", {tag, " prep cycle J/oe/busy"},
        {28'd0, oe_o, busy_o, dp_o, dm_o}, 5);
    n = 0;
    saw_rdy = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      start_i = (c == inject_at);
      if (!oe_o) break;
      if (in_ready_o && hs) saw_rdy = 1'b1;
      if (n < 1024) got_tr[n] = {dp_o, dm_o};
      n++;
    end
    start_i = 1'b0;
    chk(!busy_o, "R6", {tag, " busy low with oe release"}, int'(busy_o), 0);
    chk(n == exp_len, "R1", {tag, " driven length in cycles"}, n, exp_len);
    first_bad = -1;
    for (int i = 0; i < exp_len && i < n; i++)
      if (first_bad < 0 && got_tr[i] != exp_tr[i]) first_bad = i;
    if (first_bad >= 0)
      chk(1'b0, "R4/R5", {tag, " line symbol at cycle"}, int'(got_tr[first_bad]),
          int'(exp_tr[first_bad]));
    else
      chk(1'b1, "R4", tag, 0, 0);
    if (hs) chk(!saw_rdy, "R8", {tag, " ready stays low"}, int'(saw_rdy), 0);
    else    chk(src_i == src_n, "R7", {tag, " bytes taken"}, src_i, src_n);
  endtask

  initial begin
    #1_900_000;
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] keep;
    repeat (3) @(negedge clk);
    chk(!oe_o && !busy_o && !in_ready_o, "R2", "reset idle outputs",
        {29'd0, oe_o, busy_o, in_ready_o}, 0);
    chk(addr_o == 7'd0, "R9", "reset address", int'(addr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: both handshakes; R9: address untouched
    pend_addr_i = 7'h15;
    run_pkt(1'b1, 1'b0, 2, 0, -1, "R8 ACK");
    chk(addr_o == 7'd0, "R9", "addr after ACK", int'(addr_o), 0);
    run_pkt(1'b1, 1'b1, 2, 0, -1, "R8 NAK");
    chk(addr_o == 7'd0, "R9", "addr after NAK", int'(addr_o), 0);

    // R3: sync only
    run_pkt(1'b0, 1'b0, 1, 0, -1, "R3 sync only");
    chk(addr_o == 7'h15, "R9", "addr after sync-only data", int'(addr_o), 'h15);

    // R4/R5 sweep of every single payload byte
    for (int v = 0; v < 256; v++) begin
      src_q[0] = 8'(v);
      pend_addr_i = 7'(v + 3);
      run_pkt(1'b0, 1'b0, 2, v % 23, -1, "R4 sweep");
      chk(addr_o == 7'(v + 3), "R9", "addr after data packet", int'(addr_o), (v + 3) % 128);
    end

    // R5: stuffing across byte boundaries
    for (int i = 0; i < 4; i++) src_q[i] = 8'hFF;
    run_pkt(1'b0, 1'b0, 5, 30, -1, "R5 ones run");
    src_q[0] = 8'h7E; src_q[1] = 8'hFC; src_q[2] = 8'h3F; src_q[3] = 8'h00;
    src_q[4] = 8'hE0; src_q[5] = 8'h0F;
    run_pkt(1'b0, 1'b0, 7, 5, -1, "R5 mixed");

    // R10: start during a packet is ignored
    src_q[0] = 8'hA5; src_q[1] = 8'h3C;
    run_pkt(1'b0, 1'b0, 3, 2, 40, "R10 inject");
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !oe_o, "R10", "no second packet", int'(busy_o), 0);

    // R9: handshake after data keeps address
    keep = addr_o;
    pend_addr_i = 7'h6B;
    run_pkt(1'b1, 1'b1, 2, 0, -1, "R9 NAK");
    chk(addr_o == keep, "R9", "addr held after handshake", int'(addr_o), int'(keep));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule